// File: doc/BRIEF.md
# I2C Bus Master START Sequencer with Arbitration-Loss Detection

This block produces an I2C START condition for a bus master and watches the bus for another master while it does so. Software raises a one-cycle start request. The block takes both open-drain lines through a synchronizer and checks that both are high. It then times two hold intervals with a reloadable countdown timer. It pulls SDA low after the first interval and SCL low after the second. The bus then holds the START state until software acknowledges the completion flag. At that point both lines are released.

Another master can show up in three places. Both lines may already be low when the request arrives. SDA may fall during the first interval. SCL may fall while SDA is still high, which means another master is sending a data one. In each of these cases the block drops the sequence, clears its enable and returns to idle, and it sets a sticky collision flag. If SCL falls after the block has pulled SDA low, this is not treated as a collision.

Top module: `i2c_start_gen`

## Requirements
- R1: After a synchronous reset, `sda_pull`, `scl_pull`, `start_en`, `done_flag`, `coll_flag` and `start_seen` are 0 and `idle` is 1.
- R2: If the synchronized SDA or SCL is low in the cycle that `start_req` is taken in idle, the request is refused. `coll_flag` is set, `start_en` stays 0, `idle` stays 1 and neither line is pulled.
- R3: When a request is accepted at clock edge 0 with reload value N, `start_en` is 1 after that edge. `sda_pull` rises at edge N+1 and `scl_pull` rises at edge 2N+2.
- R4: An external low on `sda_in` during the first interval aborts the sequence. `coll_flag` is set, `start_en` is cleared and `idle` returns. `sda_pull` is never asserted. A low driven just after edge k is acted on at edge k+3.
- R5: An external low on `scl_in` while SDA is not yet pulled aborts the sequence in the same way and at the same edge as R4.
- R6: An external low on `scl_in` after `sda_pull` has risen does not set `coll_flag` and does not move the completion edge.
- R7: On completion, `done_flag` and `start_seen` are set and `start_en` is cleared, while `coll_flag` stays 0. Both pulls stay asserted until `clr_done`. One edge after `clr_done`, both pulls are 0 and `idle` is 1.
- R8: `done_flag` and `coll_flag` stay set until `clr_done` or `clr_coll`, respectively, is pulsed. `start_seen` stays set until the next accepted request.
- R9: A reload value of 0 gives one-cycle intervals: `sda_pull` rises at edge 1 and `scl_pull` at edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin a START |
| reload | input | 7 | Countdown reload value for each hold interval |
| clr_done | input | 1 | Clears the completion flag and releases the bus |
| clr_coll | input | 1 | Clears the collision flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| sda_pull | output | 1 | Active-high pull-low enable for SDA |
| scl_pull | output | 1 | Active-high pull-low enable for SCL |
| start_en | output | 1 | Start-enable state, cleared by hardware |
| done_flag | output | 1 | Sticky START-complete flag |
| coll_flag | output | 1 | Sticky bus-collision flag |
| start_seen | output | 1 | START issued on the bus |
| idle | output | 1 | Sequencer is idle |

## Verification
The bench models the bus as a wired-AND of the block's pulls and an external pull. It injects foreign lows at random edges inside the first interval and checks the exact edge at which the abort appears. That edge exposes a synchronizer that is one stage too short or too long, and a collision check placed on the wrong side of the countdown. When SCL falls during the second interval, a design that checks SCL there reports a false collision. A collision on the last cycle of the first interval is also a target: a design that gives the countdown end priority over the collision check would pull SDA low there anyway. A reload of zero catches a timer that wraps to its maximum and stalls, and a line that is already low at request time catches a missing pre-check.

// File: rtl/i2c_start_pkg.sv
`timescale 1ns/1ps
package i2c_start_pkg;
  // Phases of the START sequence
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,  // waiting for a request
    PH_SETUP    = 2'd1,  // first interval, both lines must stay high
    PH_SDA_LOW  = 2'd2,  // SDA pulled, second interval running
    PH_BUS_HELD = 2'd3   // SDA and SCL pulled, waiting for acknowledge
  } start_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pin,
  output logic [LINES-1:0] level
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= pin[i];
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;  // bus idles high
        else     chain <= {chain[STAGES-2:0], pin[i]};
      end
    end
    assign level[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_start_brg.sv
`timescale 1ns/1ps
module i2c_start_brg #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic             zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)     cnt <= '0;
    else if (load)        cnt <= reload;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign zero = (cnt == '0);

  AST_BRG_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R3
  AST_BRG_PARK: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear && cnt == '0) |=> (cnt == '0)); // R9
  AST_BRG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> zero); // R4
endmodule

// File: rtl/i2c_start_ctrl.sv
`timescale 1ns/1ps
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic clr_done,
  input  logic clr_coll,
  input  logic sda_s,
  input  logic scl_s,
  input  logic brg_zero,
  output logic brg_load,
  output logic brg_clear,
  output logic sda_pull,
  output logic scl_pull,
  output logic start_en,
  output logic done_flag,
  output logic coll_flag,
  output logic start_seen,
  output logic idle
);
  start_phase_e phase;
  logic lines_high;
  logic accept;
  logic setup_lost;

  assign lines_high = sda_s && scl_s;
  assign accept     = (phase == PH_IDLE) && start_req && lines_high;
  assign setup_lost = (phase == PH_SETUP) && !lines_high;

  always_comb begin
    brg_load  = accept || ((phase == PH_SETUP) && lines_high && brg_zero);
    brg_clear = setup_lost;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      sda_pull   <= 1'b0;
      scl_pull   <= 1'b0;
      start_en   <= 1'b0;
      done_flag  <= 1'b0;
      coll_flag  <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      if (clr_done) done_flag <= 1'b0;
      if (clr_coll) coll_flag <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start_req) begin
            if (!lines_high) begin
              coll_flag <= 1'b1;
            end else begin
              start_en   <= 1'b1;
              start_seen <= 1'b0;
              phase      <= PH_SETUP;
            end
          end
        end
        PH_SETUP: begin
          if (!lines_high) begin
            coll_flag <= 1'b1;
            start_en  <= 1'b0;
            phase     <= PH_IDLE;
          end else if (brg_zero) begin
            sda_pull <= 1'b1;
            phase    <= PH_SDA_LOW;
          end
        end
        PH_SDA_LOW: begin
          if (brg_zero) begin
            scl_pull   <= 1'b1;
            done_flag  <= 1'b1;
            start_seen <= 1'b1;
            start_en   <= 1'b0;
            phase      <= PH_BUS_HELD;
          end
        end
        PH_BUS_HELD: begin
          if (clr_done) begin
            sda_pull <= 1'b0;
            scl_pull <= 1'b0;
            phase    <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle = (phase == PH_IDLE);

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> sda_pull); // R3
  AST_SDA_LOST: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_SETUP) && !sda_s) |=> (idle && coll_flag && !sda_pull)); // R4
  AST_SCL_LOST: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_SETUP) && !scl_s) |=> (idle && coll_flag && !start_en)); // R5
  AST_SCL_LATE_OK: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_SDA_LOW) && !coll_flag && !clr_coll) |=> !coll_flag); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (!start_en && sda_pull && scl_pull && start_seen)); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!sda_pull && !scl_pull && !start_en)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !clr_done) |=> done_flag); // R8
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (coll_flag && !clr_coll) |=> coll_flag); // R8
endmodule

// File: rtl/i2c_start_gen.sv
`timescale 1ns/1ps
module i2c_start_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                clr_done,
  input  logic                clr_coll,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_pull,
  output logic                scl_pull,
  output logic                start_en,
  output logic                done_flag,
  output logic                coll_flag,
  output logic                start_seen,
  output logic                idle
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_lvl;
  logic brg_load, brg_clear, brg_zero;

  i2c_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   ({scl_in, sda_in}),
    .level (line_lvl)
  );

  i2c_start_brg #(.CNT_W(RELOAD_W)) u_brg (
    .clk    (clk),
    .rst    (rst),
    .load   (brg_load),
    .clear  (brg_clear),
    .reload (reload),
    .zero   (brg_zero)
  );

  i2c_start_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .clr_done   (clr_done),
    .clr_coll   (clr_coll),
    .sda_s      (line_lvl[0]),
    .scl_s      (line_lvl[1]),
    .brg_zero   (brg_zero),
    .brg_load   (brg_load),
    .brg_clear  (brg_clear),
    .sda_pull   (sda_pull),
    .scl_pull   (scl_pull),
    .start_en   (start_en),
    .done_flag  (done_flag),
    .coll_flag  (coll_flag),
    .start_seen (start_seen),
    .idle       (idle)
  );
endmodule

// File: tb/sim_i2c_start_gen.sv
`timescale 1ns/1ps
module sim_i2c_start_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [6:0] reload = '0;
  logic clr_done = 1'b0;
  logic clr_coll = 1'b0;
  logic ext_sda_low = 1'b0;
  logic ext_scl_low = 1'b0;
  logic sda_in, scl_in;
  logic sda_pull, scl_pull, start_en, done_flag, coll_flag, start_seen, idle;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND open-drain bus
  assign sda_in = !(sda_pull || ext_sda_low);
  assign scl_in = !(scl_pull || ext_scl_low);

  i2c_start_gen u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .reload(reload),
    .clr_done(clr_done), .clr_coll(clr_coll), .sda_in(sda_in), .scl_in(scl_in),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .start_en(start_en),
    .done_flag(done_flag), .coll_flag(coll_flag), .start_seen(start_seen), .idle(idle)
  );

  function automatic int sda_edge(int n); return n + 1; endfunction
  function automatic int scl_edge(int n); return 2 * n + 2; endfunction
  function automatic int lost_edge(int k); return k + 3; endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode 0 clean, 1 SDA lost in setup, 2 SCL lost in setup, 3 SCL low after SDA pulled
  task automatic run_seq(int n, int mode, int k, string req);
    int limit;
    bit lost;
    lost = (mode == 1 || mode == 2);
    limit = lost ? lost_edge(k) + 1 : scl_edge(n) + 2;
    reload = 7'(n);
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    check("R3", "start_en after accept", int'(start_en), 1);
    check("R8", "start_seen cleared on accept", int'(start_seen), 0);
    for (int e = 1; e <= limit; e++) begin
      if (mode == 1 && e == k + 1) ext_sda_low = 1'b1;
      if (mode == 2 && e == k + 1) ext_scl_low = 1'b1;
      if (mode == 3 && e == sda_edge(n) + 1) ext_scl_low = 1'b1;
      tick();
      if (lost) begin
        check(req, "coll_flag edge", int'(coll_flag), int'(e >= lost_edge(k)));
        check(req, "sda_pull in lost run", int'(sda_pull), 0);
        check(req, "start_en in lost run", int'(start_en), int'(e < lost_edge(k)));
      end else begin
        check(req, "sda_pull edge", int'(sda_pull), int'(e >= sda_edge(n)));
        check(req, "scl_pull edge", int'(scl_pull), int'(e >= scl_edge(n)));
        check("R7", "done_flag edge", int'(done_flag), int'(e >= scl_edge(n)));
        check("R6", "no collision", int'(coll_flag), 0);
      end
    end
    if (lost) begin
      ext_sda_low = 1'b0; ext_scl_low = 1'b0;
      check(req, "idle after loss", int'(idle), 1);
      repeat (4) tick();
      check("R8", "coll_flag sticky", int'(coll_flag), 1);
      clr_coll = 1'b1; tick(); clr_coll = 1'b0;
      check("R8", "coll_flag cleared", int'(coll_flag), 0);
    end else begin
      ext_scl_low = 1'b0;
      repeat (3) tick();
      check("R7", "start_seen", int'(start_seen), 1);
      check("R7", "start_en cleared", int'(start_en), 0);
      check("R7", "bus held", int'(sda_pull && scl_pull), 1);
      check("R8", "done_flag sticky", int'(done_flag), 1);
      clr_done = 1'b1; tick(); clr_done = 1'b0;
      check("R7", "released pulls", int'(sda_pull || scl_pull), 0);
      check("R7", "idle after release", int'(idle), 1);
      check("R8", "done_flag cleared", int'(done_flag), 0);
      check("R8", "start_seen kept", int'(start_seen), 1);
    end
    repeat (3) tick();
  endtask

  task automatic refused(bit use_sda);
    if (use_sda) ext_sda_low = 1'b1; else ext_scl_low = 1'b1;
    repeat (3) tick();
    reload = 7'd5;
    start_req = 1'b1; tick(); start_req = 1'b0;
    check("R2", "coll_flag on busy line", int'(coll_flag), 1);
    check("R2", "start_en refused", int'(start_en), 0);
    check("R2", "idle kept", int'(idle), 1);
    repeat (8) tick();
    check("R2", "no pull after refusal", int'(sda_pull || scl_pull), 0);
    ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    clr_coll = 1'b1; tick(); clr_coll = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_2c01));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    check("R1", "idle", int'(idle), 1);
    check("R1", "pulls", int'(sda_pull || scl_pull), 0);
    check("R1", "flags", int'(done_flag || coll_flag || start_seen || start_en), 0);
    repeat (2) tick();

    run_seq(0, 0, 0, "R9");
    run_seq(1, 0, 0, "R3");
    run_seq(6, 0, 0, "R3");
    run_seq(2, 3, 0, "R6");
    run_seq(5, 1, 3, "R4");   // loss on the last setup edge
    run_seq(5, 2, 3, "R5");
    run_seq(3, 1, 1, "R4");
    refused(1'b1);
    refused(1'b0);

    for (int i = 0; i < 16; i++) begin
      int n, mode, k;
      mode = int'($urandom_range(0, 3));
      n = int'($urandom_range(3, 20));
      k = int'($urandom_range(1, n - 2));
      case (mode)
        0: run_seq(n, 0, 0, "R3");
        1: run_seq(n, 1, k, "R4");
        2: run_seq(n, 2, k, "R5");
        default: run_seq(n, 3, 0, "R6");
      endcase
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule